// File: doc/BRIEF.md
# SAR DAC Self-Calibration Controller

This block is the digital sequencer that measures and corrects the five largest capacitors of a 16-bit charge-redistribution successive-approximation converter. After a start request it walks through the calibrated bank one capacitor at a time, from the smallest of the five (DAC bit 11) up to the largest (DAC bit 15). It first does this for the plus-side array and then for the minus-side array. For every capacitor it drives the array switches through a sample phase and a charge-redistribution phase. It then runs an 11-bit successive-approximation search on the lower capacitors, using the external comparator, to find how far that capacitor is from its ideal size.

Each measurement can be repeated and averaged over 1 to 32 passes. The averaged search code is turned into a signed error in units of one 16-bit LSB. The block never stores the raw errors as its result. Instead it forms a weighted running sum of the errors measured so far and writes a correction coefficient for each calibrated bit. The converter's normal conversion logic later adds these coefficients back in. The analog array and the comparator are outside this block.

Top module: `sarcal_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `top_hold_o`, `phase_o` and `dac_hi_o` are all zero, and every coefficient in `coef_o` reads zero.
- R2: A start request seen while idle is accepted at that clock edge. From the next cycle `busy_o` is high, and the run covers the plus side (`side_o`=0) first and then the minus side (`side_o`=1). On each side it steps `cut_o` from 0 (DAC bit 11) to 4 (DAC bit 15).
- R3: Each measurement pass begins with a sample phase (`phase_o`=1) that lasts SMP_CYC cycles. During it `top_hold_o` is high, and `dac_hi_o` drives high every DAC bit below the capacitor under test and low everything else.
- R4: The sample phase is followed by a redistribution phase (`phase_o`=2) of RDS_CYC cycles. During it `top_hold_o` is low and `dac_hi_o` has only the bit of the capacitor under test set.
- R5: The search phase (`phase_o`=3) lasts 11 cycles and resolves the trial code on `dac_hi_o[10:0]` from bit 10 down to bit 0. Each cycle sets the next trial bit, and that bit is kept when `cmp_i` is high and cleared when it is low. The bit of the capacitor under test stays set on `dac_hi_o` throughout.
- R6: The number of passes per capacitor is 2^m, where m = `avg_sel_i` clamped to at most 5. The search codes of those passes are summed and shifted right by m. The capacitor's error is this average minus 1024, a signed 12-bit value. One capacitor takes 16·2^m+1 cycles, so a full run keeps `busy_o` high for 10·(16·2^m+1) cycles at the default timing.
- R7: With plus-side errors E0..E4 (bit 11..bit 15), the coefficients are CL0=E0, CL1=E1+E0, CL2=E2+E1+2E0, CL3=E3+E2+2E1+4E0 and CL4=E4+2E3+4E2+8E1+16E0. They are stored as 17-bit two's-complement values in `coef_o` slot k (bits [17k+16:17k]).
- R8: The minus side uses the same formulas on its own errors and stores them in slots 5 to 9 of `coef_o` (slot 5+k holds minus-side CLk).
- R9: `done_o` rises in the cycle after the minus-side CL4 is written, together with the fall of `busy_o`. It stays high until the next accepted start.
- R10: A start request while `busy_o` is high is ignored. This includes a request in the final store cycle: the run, its coefficients and its length are unchanged, and the engine does not begin a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run a calibration |
| avg_sel_i | input | 3 | Log2 of passes per capacitor, clamped to 5, captured at start |
| cmp_i | input | 1 | Comparator result, high keeps the current trial bit |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Last run completed |
| side_o | output | 1 | Array under calibration, 0 plus, 1 minus |
| cut_o | output | 3 | Index of capacitor under test, 0 is DAC bit 11 |
| phase_o | output | 2 | 0 quiet, 1 sample, 2 redistribute, 3 search |
| top_hold_o | output | 1 | Top plates held during sampling |
| dac_hi_o | output | 16 | Per-bit switch control, 1 ties the bit to the high reference, 0 to the low |
| coef_o | output | 170 | Ten 17-bit signed coefficients, slot 0..4 plus side, 5..9 minus side |

## Verification
Two things can share one clock edge: the final store cycle, which writes the minus-side CL4, and an incoming start request. The bench holds `start_i` high exactly in that store cycle. It then expects `done_o` to rise and `busy_o` to fall at that edge, all ten coefficients to match their formulas, and the engine to stay idle for several cycles afterwards. A second run pulses start in the middle of both the plus and minus passes, and the cycle count of that run must still equal the count that R6 predicts.

// File: rtl/sarcal_pkg.sv
package sarcal_pkg;

    localparam int NCAL_DEF = 5;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_REDIST = 3'd2,
        ST_SEARCH = 3'd3,
        ST_STORE  = 3'd4
    } cal_state_e;

    localparam logic [1:0] PH_QUIET  = 2'd0;
    localparam logic [1:0] PH_SAMPLE = 2'd1;
    localparam logic [1:0] PH_REDIST = 2'd2;
    localparam logic [1:0] PH_SEARCH = 2'd3;

    // Weight of error j inside correction k; the top coefficient doubles
    // every older term once more than the others.
    function automatic int err_weight(int k, int j, int ncal);
        if (j > k)         return 0;
        if (j == k)        return 1;
        if (k == ncal - 1) return 1 << (k - j);
        return 1 << (k - j - 1);
    endfunction

endpackage

// File: rtl/sarcal_sar_step.sv
module sarcal_sar_step #(
    parameter int W = 11
) (
    input  logic [W-1:0]         trial_i,
    input  logic [$clog2(W)-1:0] bitpos_i,
    input  logic                 cmp_i,
    output logic [W-1:0]         kept_o,
    output logic [W-1:0]         next_o,
    output logic                 last_o
);
    logic [W-1:0] cur_bit;

    assign cur_bit = W'(1) << bitpos_i;
    assign kept_o  = cmp_i ? trial_i : (trial_i & ~cur_bit);
    assign next_o  = kept_o | (cur_bit >> 1);
    assign last_o  = (bitpos_i == '0);
endmodule

// File: rtl/sarcal_coef_calc.sv
module sarcal_coef_calc #(
    parameter int NCAL   = 5,
    parameter int ERR_W  = 12,
    parameter int COEF_W = 17
) (
    input  logic [NCAL-1:0][ERR_W-1:0] err_i,
    input  logic [$clog2(NCAL)-1:0]    idx_i,
    output logic [COEF_W-1:0]          coef_o
);
    logic signed [COEF_W-1:0] cand [NCAL];

    for (genvar k = 0; k < NCAL; k++) begin : g_cl
        always_comb begin
            cand[k] = '0;
            for (int j = 0; j < NCAL; j++) begin
                if (j <= k) begin
                    cand[k] = cand[k]
                        + $signed(COEF_W'(sarcal_pkg::err_weight(k, j, NCAL)))
                        * COEF_W'($signed(err_i[j]));
                end
            end
        end
    end

    always_comb begin
        coef_o = '0;
        for (int k = 0; k < NCAL; k++) begin
            if (int'(idx_i) == k) coef_o = cand[k];
        end
    end
endmodule

// File: rtl/sarcal_switch_map.sv
module sarcal_switch_map #(
    parameter int DAC_W = 16,
    parameter int NCAL  = 5
) (
    input  logic [1:0]              phase_i,
    input  logic [$clog2(NCAL)-1:0] cut_i,
    input  logic [DAC_W-NCAL-1:0]   trial_i,
    output logic [DAC_W-1:0]        dac_hi_o,
    output logic                    top_hold_o
);
    import sarcal_pkg::*;

    localparam int CAL_LSB = DAC_W - NCAL;

    logic [DAC_W-1:0] cut_bit;

    assign cut_bit    = DAC_W'(1) << (CAL_LSB + int'(cut_i));
    assign top_hold_o = (phase_i == PH_SAMPLE);

    always_comb begin
        unique case (phase_i)
            PH_SAMPLE: dac_hi_o = cut_bit - DAC_W'(1);
            PH_REDIST: dac_hi_o = cut_bit;
            PH_SEARCH: dac_hi_o = cut_bit | DAC_W'(trial_i);
            default:   dac_hi_o = '0;
        endcase
    end
endmodule

// File: rtl/sarcal_ctrl.sv
module sarcal_ctrl #(
    parameter int DAC_W        = 16,
    parameter int NCAL         = sarcal_pkg::NCAL_DEF,
    parameter int ERR_W        = 12,
    parameter int COEF_W       = 17,
    parameter int SMP_CYC      = 4,
    parameter int RDS_CYC      = 1,
    parameter int AVG_MAX_LOG2 = 5,
    parameter int SEL_W        = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [SEL_W-1:0]           avg_sel_i,
    input  logic                       cmp_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       side_o,
    output logic [$clog2(NCAL)-1:0]    cut_o,
    output logic [1:0]                 phase_o,
    output logic                       top_hold_o,
    output logic [DAC_W-1:0]           dac_hi_o,
    output logic [2*NCAL*COEF_W-1:0]   coef_o
);
    import sarcal_pkg::*;

    localparam int SRCH_W = DAC_W - NCAL;
    localparam int IDX_W  = $clog2(NCAL);
    localparam int BIT_W  = $clog2(SRCH_W);
    localparam int ACC_W  = SRCH_W + AVG_MAX_LOG2;
    localparam int MAXC   = (SMP_CYC > RDS_CYC) ? SMP_CYC : RDS_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int NLOG_W = $clog2(AVG_MAX_LOG2 + 1);
    localparam int SAMP_W = AVG_MAX_LOG2 + 1;
    localparam int CI_W   = $clog2(2 * NCAL);
    localparam int MID    = 1 << (SRCH_W - 1);

    typedef struct packed {
        cal_state_e                     st;
        logic                           side;
        logic [IDX_W-1:0]               cut;
        logic [CNT_W-1:0]               cnt;
        logic [BIT_W-1:0]               bitp;
        logic [SRCH_W-1:0]              trial;
        logic [SAMP_W-1:0]              samp;
        logic [NLOG_W-1:0]              nlog;
        logic [ACC_W-1:0]               acc;
        logic                           done;
        logic [NCAL-1:0][ERR_W-1:0]     err;
        logic [2*NCAL-1:0][COEF_W-1:0]  coef;
    } ctl_t;

    ctl_t q, d;

    logic [SRCH_W-1:0]          step_kept, step_next;
    logic                       step_last;
    logic [SRCH_W-1:0]          avg_code;
    logic [ERR_W-1:0]           new_err;
    logic [NCAL-1:0][ERR_W-1:0] err_mux;
    logic [COEF_W-1:0]          coef_new;
    logic [SAMP_W-1:0]          samp_last;
    logic [CI_W-1:0]            cidx;

    sarcal_sar_step #(.W(SRCH_W)) u_step (
        .trial_i (q.trial),
        .bitpos_i(q.bitp),
        .cmp_i   (cmp_i),
        .kept_o  (step_kept),
        .next_o  (step_next),
        .last_o  (step_last)
    );

    assign avg_code  = SRCH_W'(q.acc >> q.nlog);
    assign new_err   = ERR_W'({1'b0, avg_code}) - ERR_W'(MID);
    assign samp_last = SAMP_W'((32'd1 << q.nlog) - 32'd1);
    assign cidx      = q.side ? (CI_W'(NCAL) + CI_W'(q.cut)) : CI_W'(q.cut);

    always_comb begin
        err_mux        = q.err;
        err_mux[q.cut] = new_err;
    end

    sarcal_coef_calc #(.NCAL(NCAL), .ERR_W(ERR_W), .COEF_W(COEF_W)) u_coef (
        .err_i (err_mux),
        .idx_i (q.cut),
        .coef_o(coef_new)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_SAMPLE;
                    d.side = 1'b0;
                    d.cut  = '0;
                    d.cnt  = '0;
                    d.samp = '0;
                    d.acc  = '0;
                    d.done = 1'b0;
                    d.nlog = (int'(avg_sel_i) > AVG_MAX_LOG2) ? NLOG_W'(AVG_MAX_LOG2)
                                                              : NLOG_W'(avg_sel_i);
                end
            end
            ST_SAMPLE: begin
                if (q.cnt == CNT_W'(SMP_CYC - 1)) begin
                    d.st  = ST_REDIST;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_REDIST: begin
                if (q.cnt == CNT_W'(RDS_CYC - 1)) begin
                    d.st    = ST_SEARCH;
                    d.cnt   = '0;
                    d.bitp  = BIT_W'(SRCH_W - 1);
                    d.trial = SRCH_W'(1) << (SRCH_W - 1);
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_SEARCH: begin
                if (step_last) begin
                    d.acc   = q.acc + ACC_W'(step_kept);
                    d.trial = '0;
                    if (q.samp == samp_last) begin
                        d.st = ST_STORE;
                    end else begin
                        d.samp = q.samp + SAMP_W'(1);
                        d.st   = ST_SAMPLE;
                    end
                end else begin
                    d.trial = step_next;
                    d.bitp  = q.bitp - BIT_W'(1);
                end
            end
            ST_STORE: begin
                d.err[q.cut]  = new_err;
                d.coef[cidx]  = coef_new;
                d.acc         = '0;
                d.samp        = '0;
                d.st          = ST_SAMPLE;
                if (q.cut == IDX_W'(NCAL - 1)) begin
                    d.cut = '0;
                    if (q.side) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.side = 1'b1;
                    end
                end else begin
                    d.cut = q.cut + IDX_W'(1);
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (q.st)
            ST_SAMPLE: phase_o = PH_SAMPLE;
            ST_REDIST: phase_o = PH_REDIST;
            ST_SEARCH: phase_o = PH_SEARCH;
            default:   phase_o = PH_QUIET;
        endcase
    end

    sarcal_switch_map #(.DAC_W(DAC_W), .NCAL(NCAL)) u_sw (
        .phase_i   (phase_o),
        .cut_i     (q.cut),
        .trial_i   (q.trial),
        .dac_hi_o  (dac_hi_o),
        .top_hold_o(top_hold_o)
    );

    assign busy_o = (q.st != ST_IDLE);
    assign done_o = q.done;
    assign side_o = q.side;
    assign cut_o  = q.cut;
    assign coef_o = q.coef;
endmodule

// File: rtl/sarcal_ctrl_chk.sv
module sarcal_ctrl_chk #(
    parameter int DAC_W = 16,
    parameter int NCAL  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic                    side_o,
    input logic [$clog2(NCAL)-1:0] cut_o,
    input logic [1:0]              phase_o,
    input logic                    top_hold_o,
    input logic [DAC_W-1:0]        dac_hi_o
);
    localparam int SRCH_W = DAC_W - NCAL;

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && phase_o == 2'd0));

    // R3
    sample_plate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1) |-> (top_hold_o && (&dac_hi_o[SRCH_W-1:0])));

    // R4
    redist_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |-> (!top_hold_o && $countones(dac_hi_o) == 1
                               && dac_hi_o[SRCH_W-1:0] == '0));

    // R5
    search_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && $past(phase_o) == 2'd3) |->
        ($countones(dac_hi_o[SRCH_W-1:0]) <= $countones($past(dac_hi_o[SRCH_W-1:0])) + 1));

    // R2
    first_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!side_o && cut_o == '0 && phase_o == 2'd1));

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(busy_o) && $past(side_o)
                           && $past(cut_o) == ($clog2(NCAL))'(NCAL - 1)));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && side_o && start_i) |=> (side_o || done_o));
endmodule

bind sarcal_ctrl sarcal_ctrl_chk #(.DAC_W(DAC_W), .NCAL(NCAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .side_o    (side_o),
    .cut_o     (cut_o),
    .phase_o   (phase_o),
    .top_hold_o(top_hold_o),
    .dac_hi_o  (dac_hi_o)
);

// File: tb/sim_sarcal_ctrl.sv
module sim_sarcal_ctrl;
    localparam int CW   = 17;
    localparam int PASS = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   avg_sel_i = '0;
    logic         cmp_i = 1'b0;
    logic         busy_o, done_o, side_o, top_hold_o;
    logic [2:0]   cut_o;
    logic [1:0]   phase_o;
    logic [15:0]  dac_hi_o;
    logic [169:0] coef_o;

    sarcal_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .avg_sel_i(avg_sel_i),
        .cmp_i(cmp_i), .busy_o(busy_o), .done_o(done_o), .side_o(side_o),
        .cut_o(cut_o), .phase_o(phase_o), .top_hold_o(top_hold_o),
        .dac_hi_o(dac_hi_o), .coef_o(coef_o)
    );

    always #2 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    int exp_q[$];
    int exp_cyc_q[$];
    int base_tab [2][5];
    int offs [4] = '{0, 3, -1, 2};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Behavioural array and comparator: keep trial bit while code <= target
    int   samp_n = 0;
    logic [1:0] prev_ph = 2'd0;
    always @(negedge clk) begin
        int tgt;
        if (phase_o == 2'd0) samp_n = 0;
        else if (phase_o == 2'd2 && prev_ph != 2'd2) samp_n++;
        prev_ph = phase_o;
        tgt = base_tab[side_o][cut_o] + offs[(samp_n + 3) % 4];
        cmp_i = (int'(dac_hi_o[10:0]) <= tgt);
    end

    // Monitor: compares coefficients and run length when done rises
    int busy_cnt = 0;
    bit done_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_cnt++;
            if (done_o && !done_seen) begin
                if (exp_q.size() < 10 || exp_cyc_q.size() < 1) begin
                    chk(1'b0, "R9", "unexpected completion", 1, 0);
                end else begin
                    int ec;
                    for (int i = 0; i < 10; i++) begin
                        int e;
                        int a;
                        e = exp_q.pop_front();
                        a = int'($signed(coef_o[i*CW +: CW]));
                        chk(a == e, (i < 5) ? "R7" : "R8", $sformatf("coef slot %0d", i), a, e);
                    end
                    ec = exp_cyc_q.pop_front();
                    chk(busy_cnt == ec, "R6", "busy cycles", busy_cnt, ec);
                end
                busy_cnt = 0;
            end
            done_seen = done_o;
        end
    end

    function automatic void push_side(input int e [5]);
        exp_q.push_back(e[0]);
        exp_q.push_back(e[0] + e[1]);
        exp_q.push_back(e[2] + e[1] + 2*e[0]);
        exp_q.push_back(e[3] + e[2] + 2*e[1] + 4*e[0]);
        exp_q.push_back(e[4] + 2*e[3] + 4*e[2] + 8*e[1] + 16*e[0]);
    endfunction

    // Driver: pushes expected results, then runs one calibration.
    // mode 0 plain, 1 first-cap phase checks, 2 mid-run start pulses,
    // 3 start in the last store cycle.
    task automatic run_cal(input int sel, input int eff, input int b [10], input int mode);
        int e [5];
        int nsmp;
        nsmp = 1 << eff;
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 5; k++) begin
                base_tab[s][k] = b[s*5 + k];
                e[k] = b[s*5 + k] + ((nsmp >= 2) ? 1 : 0) - 1024;
            end
            push_side(e);
        end
        exp_cyc_q.push_back(10 * (nsmp * PASS + 1));

        @(negedge clk);
        avg_sel_i = 3'(sel);
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);

        if (mode == 1) begin
            int c;
            chk(side_o == 1'b0 && cut_o == 3'd0, "R2", "first capacitor", {side_o, cut_o}, 0);
            chk(dac_hi_o == 16'h07FF && top_hold_o, "R3", "sample switches", dac_hi_o, 16'h07FF);
            c = 0;
            while (phase_o == 2'd1 && c < 20) begin
                c++;
                @(negedge clk);
            end
            chk(c == 4, "R3", "sample length", c, 4);
            chk(phase_o == 2'd2 && dac_hi_o == 16'h0800 && !top_hold_o, "R4",
                "redistribute switches", dac_hi_o, 16'h0800);
            @(negedge clk);
            chk(phase_o == 2'd3 && dac_hi_o == 16'h0C00, "R5", "first trial", dac_hi_o, 16'h0C00);
        end else if (mode == 2) begin
            repeat (200) @(negedge clk);
            start_i = 1'b1;           // R10: request during plus side
            @(negedge clk);
            start_i = 1'b0;
            repeat (200) @(negedge clk);
            start_i = 1'b1;           // R10: request during minus side
            @(negedge clk);
            start_i = 1'b0;
        end else if (mode == 3) begin
            while (!(busy_o && side_o && cut_o == 3'd4 && phase_o == 2'd0)) @(negedge clk);
            start_i = 1'b1;           // coincides with last coefficient write
            @(negedge clk);
            start_i = 1'b0;
            chk(done_o && !busy_o, "R9", "done with start in store cycle", {done_o, busy_o}, 2);
            repeat (5) @(negedge clk);
            chk(!busy_o, "R10", "no restart from store-cycle request", busy_o, 0);
            chk(done_o, "R9", "done held", done_o, 1);
        end

        while (!done_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done_o && !busy_o, "R9", "done stays high while idle", {done_o, busy_o}, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags after reset", {busy_o, done_o}, 0);
        chk(phase_o == 2'd0 && top_hold_o == 1'b0, "R1", "phase after reset", phase_o, 0);
        chk(dac_hi_o == '0, "R1", "switches after reset", dac_hi_o, 0);
        chk(coef_o == '0, "R1", "coefficients after reset", (coef_o != '0), 0);

        // R6 one pass each, R5 extremes of the search range
        run_cal(0, 0, '{1029, 1021, 0, 2047, 1100, 1030, 1018, 1024, 1010, 1040}, 1);
        // four passes, requests while busy (R10)
        run_cal(2, 2, '{1040, 1012, 1030, 1001, 1060, 990, 1050, 1024, 1070, 1003}, 2);
        // selector above the limit clamps to 32 passes, request in last store cycle
        run_cal(7, 5, '{1024, 1025, 1026, 1027, 1028, 1000, 1001, 1002, 1003, 1004}, 3);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all expected results consumed", exp_q.size(), 0);
        wrap_up();
    end
endmodule